// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte Writes

This block is a synthesizable behavioural model of a synchronous static memory with a registered (pipelined) read path, a four-beat burst address counter and byte-granular writes. It decodes three chip-select inputs, two address strobes, an advance input and the write controls on every rising clock edge. From these it classifies the cycle as a deselect, the start of a new burst, a step to the next burst address, or a repeat of the current address. It then performs the write or the read at the chosen word.

The two strobes behave differently. The processor strobe only counts when the chip enable is low, and it always starts a read. The controller strobe counts whatever the chip enable is, and it may start either a read or a write. A read whose address is captured on one edge drives its data after the next edge, so a four-beat burst shows the 3-1-1-1 pattern. Data is returned through an output register and a separate output-enable flag that stands in for a tri-state pad. A sleep input acts as a clock enable and holds every register and the array contents.

Top module: `pipe_burst_sram`

## Requirements
- R1: The chip is selected only when `chipEnN`=0, `sel0`=1 and `sel1N`=0. A strobe seen while not selected starts no access. `dataOe` is low after the second edge that follows such a deselect, so a read already in flight still presents its data for one cycle.
- R2: `procStrobeN` is ignored while `chipEnN` is high. `ctrlStrobeN` low is honoured even when `chipEnN` is high, and in that case it forms a deselect.
- R3: The word addressed on edge k is driven on `dataOut` with `dataOe` high after edge k+1. Back-to-back accesses deliver one word per cycle.
- R4: A cycle started by `procStrobeN` low (with `chipEnN` low) is a read. All write controls are ignored in that cycle and the array is unchanged.
- R5: `globalWrN` low in a write-capable cycle writes all four byte lanes, whatever `byteWrEnN` and `byteSelN` are.
- R6: With `globalWrN` high and `byteWrEnN` low, each `byteSelN[i]`=0 writes lane i, which is bits 8i+7 down to 8i. Any combination of lanes may be written together. With `byteWrEnN` and `globalWrN` both high, no lane is written.
- R7: In any cycle whose decoded write mask is non-zero, `dataOe` is low in that same cycle.
- R8: With both strobes inactive and a burst open, `advN`=0 moves to the next beat. Address bits above bit 1 are held. With `interleaveOrder`=0 the low two bits are (start + beat) mod 4; with `interleaveOrder`=1 they are start XOR beat. After the fourth beat the sequence wraps.
- R9: With both strobes inactive, a burst open and `advN`=1, the same address is accessed again, as a read or a write according to the write controls.
- R10: `outEnN` high forces `dataOe` low at once, with no clock edge needed. Returning it low re-enables the output without a clock edge.
- R11: While `sleep` is high, `dataOe` is low, no register changes, and the array is not written. The first cycle after sleep must be a deselect.
- R12: After reset `dataOe` is low and no burst is open, so advance-only cycles access nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | High freezes all state (clock enable) |
| chipEnN | input | 1 | Active-low chip enable, also qualifies the processor strobe |
| sel0 | input | 1 | Active-high chip select |
| sel1N | input | 1 | Active-low chip select |
| procStrobeN | input | 1 | Processor address strobe, active low, read-only start |
| ctrlStrobeN | input | 1 | Controller address strobe, active low, not qualified by enable |
| advN | input | 1 | Active-low burst advance |
| globalWrN | input | 1 | Active-low write of all lanes |
| byteWrEnN | input | 1 | Active-low enable for the per-lane selects |
| byteSelN | input | 4 | Active-low per-lane write selects, bit i for bits 8i+7:8i |
| interleaveOrder | input | 1 | Static burst order: 1 interleaved, 0 linear |
| outEnN | input | 1 | Asynchronous active-low output enable |
| addr | input | AW (6) | Word address |
| dataIn | input | 32 | Write data |
| dataOut | output | 32 | Registered read data |
| dataOe | output | 1 | High when the data pins would be driven |

## Verification
Two functions can land in the same cycle: a write being decoded while the output register still holds a finished read, and a deselect being decoded while the previous read's word is still emerging. The bench provokes the first by issuing two reads and then applying a write. It expects `dataOe` to drop before any edge, with `dataOut` still holding the read word. It provokes the second by placing a deselect (by the controller strobe, or by either select) directly behind a read. It expects the read word with `dataOe` high after one edge, and `dataOe` low after the next.

// File: rtl/sram_pkg.sv
package sram_pkg;
  parameter int LANES = 4;
  parameter int BURST_BITS = 2;

  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_DESEL,
    CYC_BEGIN,
    CYC_CONT,
    CYC_SUSP
  } cycle_e;

  // registered strobes from control to datapath
  typedef struct packed {
    logic             rdEn;
    logic [LANES-1:0] wrMask;
  } pipeCmd_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             chipEnN,
  input  logic             sel0,
  input  logic             sel1N,
  input  logic             procStrobeN,
  input  logic             ctrlStrobeN,
  input  logic             advN,
  input  logic             globalWrN,
  input  logic             byteWrEnN,
  input  logic [LANES-1:0] byteSelN,
  input  logic             interleaveOrder,
  input  logic [AW-1:0]    addr,
  output pipeCmd_t         cmdQ,
  output logic [AW-1:0]    addrQ,
  output logic             writeNow
);
  localparam int HI_W = AW - BURST_BITS;

  logic                  active;
  logic [AW-1:0]         baseAddr;
  logic [BURST_BITS-1:0] beat;
  logic [BURST_BITS-1:0] nextBeat;
  logic                  selected;
  logic                  procReq;
  logic                  startReq;
  cycle_e                kind;
  logic [LANES-1:0]      rawMask;
  logic [LANES-1:0]      mask;
  logic [AW-1:0]         accAddr;
  pipeCmd_t              nextCmd;

  function automatic logic [BURST_BITS-1:0] beatLow(
    input logic [BURST_BITS-1:0] start,
    input logic [BURST_BITS-1:0] step,
    input logic                  ilv
  );
    return ilv ? (start ^ step) : (start + step);
  endfunction

  always_comb begin
    selected = !chipEnN && sel0 && !sel1N;
    procReq  = !chipEnN && !procStrobeN;
    startReq = procReq || !ctrlStrobeN;

    if (startReq)    kind = selected ? CYC_BEGIN : CYC_DESEL;
    else if (active) kind = advN ? CYC_SUSP : CYC_CONT;
    else             kind = CYC_NONE;

    if (!globalWrN)      rawMask = '1;
    else if (!byteWrEnN) rawMask = ~byteSelN;
    else                 rawMask = '0;

    mask = '0;
    if ((kind == CYC_BEGIN && !procReq) || kind == CYC_CONT || kind == CYC_SUSP)
      mask = rawMask;

    nextBeat = (kind == CYC_CONT) ? beat + 1'b1 : beat;

    if (kind == CYC_BEGIN)
      accAddr = addr;
    else
      accAddr = {baseAddr[AW-1:BURST_BITS],
                 beatLow(baseAddr[BURST_BITS-1:0], nextBeat, interleaveOrder)};

    nextCmd.rdEn   = (kind == CYC_BEGIN || kind == CYC_CONT || kind == CYC_SUSP)
                     && (mask == '0);
    nextCmd.wrMask = mask;
    writeNow       = |mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      baseAddr <= '0;
      beat     <= '0;
      cmdQ     <= '0;
      addrQ    <= '0;
    end else if (!hold) begin
      if (kind == CYC_BEGIN) begin
        active   <= 1'b1;
        baseAddr <= addr;
        beat     <= '0;
      end else begin
        if (kind == CYC_DESEL) active <= 1'b0;
        beat <= nextBeat;
      end
      cmdQ  <= nextCmd;
      addrQ <= accAddr;
    end
  end

  logic [HI_W-1:0] unusedHi;
  assign unusedHi = baseAddr[AW-1:BURST_BITS];
endmodule

// File: rtl/sram_dpath.sv
module sram_dpath
  import sram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hold,
  input  pipeCmd_t                cmd,
  input  logic [AW-1:0]           addrQ,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    writeNow,
  input  logic                    outEnN,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataOe
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] dataQ;
  logic [DW-1:0] rdWord;
  logic [DW-1:0] outReg;
  logic          outValid;

  always_ff @(posedge clk) begin
    if (!hold) dataQ <= dataIn;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (!hold && cmd.wrMask[g])
        laneMem[addrQ] <= dataQ[g*LANE_W +: LANE_W];
    end

    assign rdWord[g*LANE_W +: LANE_W] = laneMem[addrQ];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outReg   <= '0;
      outValid <= 1'b0;
    end else if (!hold) begin
      if (cmd.rdEn) outReg <= rdWord;
      outValid <= cmd.rdEn;
    end
  end

  assign dataOut = outReg;
  assign dataOe  = outValid && !outEnN && !writeNow && !hold;
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
  import sram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  logic                    chipEnN,
  input  logic                    sel0,
  input  logic                    sel1N,
  input  logic                    procStrobeN,
  input  logic                    ctrlStrobeN,
  input  logic                    advN,
  input  logic                    globalWrN,
  input  logic                    byteWrEnN,
  input  logic [LANES-1:0]        byteSelN,
  input  logic                    interleaveOrder,
  input  logic                    outEnN,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataOe
);
  pipeCmd_t      cmdBus;
  logic [AW-1:0] addrQ;
  logic          writeNow;

  sram_ctrl #(.AW(AW)) ctrl (
    .clk(clk), .rst_n(rst_n), .hold(sleep),
    .chipEnN(chipEnN), .sel0(sel0), .sel1N(sel1N),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advN(advN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .byteSelN(byteSelN),
    .interleaveOrder(interleaveOrder), .addr(addr),
    .cmdQ(cmdBus), .addrQ(addrQ), .writeNow(writeNow)
  );

  sram_dpath #(.AW(AW), .LANE_W(LANE_W)) dpath (
    .clk(clk), .rst_n(rst_n), .hold(sleep),
    .cmd(cmdBus), .addrQ(addrQ), .dataIn(dataIn),
    .writeNow(writeNow), .outEnN(outEnN),
    .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/sram_chk.sv
module sram_chk
  import sram_pkg::*;
#(
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep,
  input logic             chipEnN,
  input logic             sel0,
  input logic             sel1N,
  input logic             procStrobeN,
  input logic             ctrlStrobeN,
  input logic             globalWrN,
  input logic             byteWrEnN,
  input logic             outEnN,
  input logic [DW-1:0]    dataOut,
  input logic             dataOe,
  input logic             cmdRd,
  input logic [LANES-1:0] cmdWrMask
);
  logic selNow;
  logic startNow;
  assign selNow   = !chipEnN && sel0 && !sel1N;
  assign startNow = (!chipEnN && !procStrobeN) || !ctrlStrobeN;

  // R1
  desel_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (startNow && !selNow && !sleep) ##1 !sleep |=> !dataOe);

  // R2
  ctrl_strobe_ungated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chipEnN && !ctrlStrobeN && !sleep) |=> (!cmdRd && cmdWrMask == '0));

  // R4
  proc_start_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chipEnN && !procStrobeN && selNow && !sleep) |=> (cmdRd && cmdWrMask == '0));

  // R5
  global_write_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!globalWrN && !ctrlStrobeN && procStrobeN && selNow && !sleep)
      |=> (cmdWrMask == {LANES{1'b1}}));

  // R6
  no_write_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (globalWrN && byteWrEnN && !sleep) |=> (cmdWrMask == '0));

  // R7
  write_kills_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (selNow && !ctrlStrobeN && procStrobeN && !globalWrN) |-> !dataOe);

  // R10
  oe_pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outEnN |-> !dataOe);

  // R11
  sleep_holds_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(dataOut));

  // R11
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dataOe);
endmodule

bind pipe_burst_sram sram_chk #(.DW(sram_pkg::LANES * LANE_W)) chkInst (
  .clk(clk), .rst_n(rst_n), .sleep(sleep),
  .chipEnN(chipEnN), .sel0(sel0), .sel1N(sel1N),
  .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
  .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .outEnN(outEnN),
  .dataOut(dataOut), .dataOe(dataOe),
  .cmdRd(cmdBus.rdEn), .cmdWrMask(cmdBus.wrMask)
);

// File: tb/pipe_burst_sram_test.sv
module pipe_burst_sram_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep = 1'b0;
  logic        chipEnN = 1'b1;
  logic        sel0 = 1'b1;
  logic        sel1N = 1'b0;
  logic        procStrobeN = 1'b1;
  logic        ctrlStrobeN = 1'b1;
  logic        advN = 1'b1;
  logic        globalWrN = 1'b1;
  logic        byteWrEnN = 1'b1;
  logic [3:0]  byteSelN = 4'hF;
  logic        interleaveOrder = 1'b0;
  logic        outEnN = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] dataIn = '0;
  logic [31:0] dataOut;
  logic        dataOe;

  int nErr = 0;
  int nChecks = 0;
  logic [31:0] model [64];

  always #10 clk = ~clk;

  pipe_burst_sram uut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep),
    .chipEnN(chipEnN), .sel0(sel0), .sel1N(sel1N),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advN(advN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .byteSelN(byteSelN),
    .interleaveOrder(interleaveOrder), .outEnN(outEnN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  function automatic logic [31:0] pat(input int a);
    return 32'h5A00_0000 ^ (a * 32'h0001_0307);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writesOff();
    globalWrN = 1'b1; byteWrEnN = 1'b1; byteSelN = 4'hF;
  endtask

  task automatic desel();
    chipEnN = 1'b1; ctrlStrobeN = 1'b0; procStrobeN = 1'b1; advN = 1'b1;
    sel0 = 1'b1; sel1N = 1'b0; writesOff();
  endtask

  task automatic rdBegin(input int a, input bit useProc);
    chipEnN = 1'b0; sel0 = 1'b1; sel1N = 1'b0; advN = 1'b1;
    procStrobeN = !useProc; ctrlStrobeN = useProc; addr = 6'(a);
    writesOff();
  endtask

  task automatic wrBegin(input int a, input logic [31:0] d, input logic gwN,
                         input logic bweN, input logic [3:0] selN);
    chipEnN = 1'b0; sel0 = 1'b1; sel1N = 1'b0; advN = 1'b1;
    procStrobeN = 1'b1; ctrlStrobeN = 1'b0; addr = 6'(a); dataIn = d;
    globalWrN = gwN; byteWrEnN = bweN; byteSelN = selN;
  endtask

  task automatic step(input bit advance);
    chipEnN = 1'b1; procStrobeN = 1'b1; ctrlStrobeN = 1'b1; advN = !advance;
    writesOff();
  endtask

  task automatic readCheck(input int a, input string req);
    rdBegin(a, 1'b0);
    tick();
    desel();
    tick();
    check(req, dataOut, model[a]);
    check(req, {31'b0, dataOe}, 32'd1);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R12 reset state
    check("R12 oe in reset", {31'b0, dataOe}, 32'd0);
    rst_n = 1'b1;
    tick();
    check("R12 oe after reset", {31'b0, dataOe}, 32'd0);
    chipEnN = 1'b0; advN = 1'b0;
    tick(); tick();
    check("R12 advance without burst", {31'b0, dataOe}, 32'd0);

    // preload every word with global writes
    for (int a = 0; a < 64; a++) begin
      wrBegin(a, pat(a), 1'b0, 1'b1, 4'hF);
      model[a] = pat(a);
      tick();
    end

    // R3 R4: processor-strobe read stream with global write held low
    for (int a = 0; a < 64; a++) begin
      rdBegin(a, 1'b1);
      globalWrN = 1'b0; dataIn = ~pat(a);
      tick();
      if (a > 0) begin
        check("R3 stream data", dataOut, model[a-1]);
        check("R3 stream oe", {31'b0, dataOe}, 32'd1);
      end
    end
    desel();
    tick();
    check("R3 stream last", dataOut, model[63]);
    tick();

    // R4: controller-strobe read stream, array untouched by the reads above
    for (int a = 0; a < 64; a++) begin
      rdBegin(a, 1'b0);
      tick();
      if (a > 0) check("R4 array unchanged", dataOut, model[a-1]);
    end
    desel();
    tick();
    check("R4 array unchanged", dataOut, model[63]);
    tick();

    // R6: every lane mask
    for (int m = 0; m < 16; m++) begin
      logic [31:0] d;
      d = 32'hC3A5_9600 + 32'(m * 17);
      wrBegin(12, d, 1'b1, 1'b0, ~4'(m));
      tick();
      for (int l = 0; l < 4; l++)
        if (m[l]) model[12][l*8 +: 8] = d[l*8 +: 8];
      readCheck(12, "R6 lane mask");
    end
    // R6: selects active but lane enable high
    wrBegin(12, 32'hDEAD_BEEF, 1'b1, 1'b1, 4'h0);
    tick();
    readCheck(12, "R6 lane enable off");
    // R5: global write overrides a partial lane select
    wrBegin(13, 32'h1234_5678, 1'b0, 1'b0, 4'b1110);
    model[13] = 32'h1234_5678;
    tick();
    readCheck(13, "R5 global overrides");

    // R7: write decoded while a read word is on the outputs
    rdBegin(14, 1'b0);
    tick();
    rdBegin(14, 1'b0);
    tick();
    check("R7 oe before write", {31'b0, dataOe}, 32'd1);
    wrBegin(15, 32'h0F0F_0F0F, 1'b1, 1'b0, 4'b0111);
    #1;
    check("R7 oe during write", {31'b0, dataOe}, 32'd0);
    check("R7 data held", dataOut, model[14]);
    model[15][31:24] = 8'h0F;
    tick();
    desel();
    tick();
    tick();
    readCheck(15, "R7 lane write landed");

    // R8 R3: read bursts, both orders, all start offsets
    for (int ilv = 0; ilv < 2; ilv++) begin
      for (int s = 0; s < 4; s++) begin
        int base;
        base = 40 + s;
        interleaveOrder = ilv[0];
        rdBegin(base, 1'b1);
        tick();
        for (int b = 0; b < 4; b++) begin
          logic [1:0] lo;
          if (b < 3) step(1'b1); else desel();
          tick();
          lo = ilv[0] ? (2'(s) ^ 2'(b)) : (2'(s) + 2'(b));
          check("R8 burst beat", dataOut, model[40 + lo]);
          check("R3 burst oe", {31'b0, dataOe}, 32'd1);
        end
        tick();
        check("R1 single cycle off", {31'b0, dataOe}, 32'd0);
      end
    end

    // R8: linear write burst starting at offset 2
    interleaveOrder = 1'b0;
    wrBegin(34, 32'hA000_0001, 1'b0, 1'b1, 4'hF);
    model[34] = 32'hA000_0001;
    tick();
    for (int b = 1; b < 4; b++) begin
      step(1'b1);
      globalWrN = 1'b0;
      dataIn = 32'hA000_0001 + 32'(b);
      model[32 + ((2 + b) % 4)] = dataIn;
      tick();
    end
    desel();
    tick();
    for (int a = 32; a < 36; a++) readCheck(a, "R8 write burst");

    // R9: suspend repeats the address, then advance resumes
    rdBegin(5, 1'b0);
    tick();
    step(1'b0);
    tick();
    check("R9 first", dataOut, model[5]);
    step(1'b0);
    tick();
    check("R9 repeat", dataOut, model[5]);
    step(1'b1);
    tick();
    check("R9 repeat", dataOut, model[5]);
    desel();
    tick();
    check("R8 after suspend", dataOut, model[6]);
    tick();

    // R2: processor strobe with enable high is ignored (suspend continues)
    rdBegin(10, 1'b1);
    tick();
    chipEnN = 1'b1; procStrobeN = 1'b0; ctrlStrobeN = 1'b1; advN = 1'b1; addr = 6'd11;
    tick();
    desel();
    tick();
    check("R2 proc strobe gated", dataOut, model[10]);
    check("R2 oe", {31'b0, dataOe}, 32'd1);
    tick();
    check("R2 ctrl strobe deselects", {31'b0, dataOe}, 32'd0);

    // R1: deselect through each select pin
    for (int v = 0; v < 2; v++) begin
      rdBegin(16, 1'b0);
      tick();
      rdBegin(3, 1'b1);
      if (v == 0) sel0 = 1'b0; else sel1N = 1'b1;
      tick();
      check("R1 in-flight word", dataOut, model[16]);
      check("R1 in-flight oe", {31'b0, dataOe}, 32'd1);
      tick();
      check("R1 select off", {31'b0, dataOe}, 32'd0);
      desel();
      tick();
    end

    // R10: output enable acts without a clock
    rdBegin(9, 1'b0);
    tick();
    desel();
    outEnN = 1'b1;
    tick();
    check("R10 oe pin high", {31'b0, dataOe}, 32'd0);
    check("R10 word registered", dataOut, model[9]);
    outEnN = 1'b0;
    #1;
    check("R10 oe pin low", {31'b0, dataOe}, 32'd1);
    tick();

    // R11: sleep freezes everything
    rdBegin(8, 1'b0);
    tick();
    tick();
    check("R11 before sleep", {31'b0, dataOe}, 32'd1);
    sleep = 1'b1;
    wrBegin(7, 32'h0BAD_0BAD, 1'b0, 1'b1, 4'hF);
    #1;
    check("R11 oe in sleep", {31'b0, dataOe}, 32'd0);
    tick(); tick(); tick();
    check("R11 out frozen", dataOut, model[8]);
    desel();
    sleep = 1'b0;
    tick();
    readCheck(7, "R11 no write in sleep");

    finishRun();
  end
endmodule